// File: doc/BRIEF.md
# Fast System Call Entry Unit

This unit produces the architectural state a processor core takes on when a fast system-call instruction retires. The core raises a one-cycle start strobe together with the current instruction pointer, the length of the instruction, the flags register, two mode bits and a set of configuration registers. One cycle later the unit answers in one of two ways. It can raise an invalid-opcode fault. Otherwise it returns the new code and stack selectors with their cached segment attributes, the return address, the saved flags image, the new flags and the new instruction pointer.

There are two entry recipes. In long mode the unit saves the full 64-bit return address and a flags image, masks the flags through a software-programmed mask, and takes its target from one of two 64-bit target registers. In legacy mode it truncates the return address to 32 bits, clears a fixed set of flags, and takes its target from the low half of the packed selector/target register. Both recipes take their selector base from bits 47:32 of that same packed register.

Top module: `syscall_entry_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is zero.
- R2: A start with the enable input low makes `fault` high for exactly one cycle on the next cycle, with `flt_code` equal to 0 and `done` low. All state outputs keep their previous values.
- R3: A start with the enable input high makes `done` high for exactly one cycle on the next cycle. `done` and `fault` are never high together, and neither goes high without a start on the cycle before.
- R4: With base B equal to `sel_tgt[47:32]`, `cs_sel` is B with bits 1:0 cleared and `ss_sel` is (B+8) modulo 2^16 with bits 1:0 cleared.
- R5: Attribute bits are, from bit 7 down to bit 0: granular, present, code/data, code, readable-or-writable, accessed, long, big. `cs_attr` is 0xFE in long mode and 0xFD in legacy mode. `ss_attr` is always 0xED. `seg_base` is 0 and `seg_limit` is 0xFFFFFFFF.
- R6: In long mode, `ret_addr` is `cur_ip + ilen` modulo 2^64. `saved_flags` is `flags_in` with bit 16 (resume) cleared, and `save_we` pulses together with `done`.
- R7: In long mode, `new_flags` is `flags_in` with every bit set in `fmask` cleared and bit 16 also cleared.
- R8: In long mode, `new_ip` is `tgt64` when `cs64` is high and `tgt_compat` when it is low.
- R9: In legacy mode, `ret_addr` is the low 32 bits of `cur_ip + ilen`, zero-extended. `save_we` stays low and `saved_flags` keeps its value.
- R10: In legacy mode, `new_flags` is `flags_in` with bits 9 (interrupt enable), 16 (resume) and 17 (virtual-8086) cleared. `fmask` has no effect.
- R11: In legacy mode, `new_ip` is `sel_tgt[31:0]`, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to process a system call |
| cur_ip | input | 64 | Current instruction pointer |
| ilen | input | 4 | Length of the system-call instruction |
| flags_in | input | 32 | Current flags register |
| long_mode | input | 1 | Long mode active |
| cs64 | input | 1 | Caller runs 64-bit code |
| sce_en | input | 1 | System-call enable bit |
| sel_tgt | input | 64 | Packed selector base (47:32) and legacy target (31:0) |
| tgt64 | input | 64 | Target for 64-bit callers |
| tgt_compat | input | 64 | Target for compatibility-mode callers |
| fmask | input | 32 | Flag mask for long mode |
| done | output | 1 | New state valid |
| fault | output | 1 | Invalid-opcode fault |
| flt_code | output | 16 | Fault error code |
| cs_sel | output | 16 | New code selector |
| ss_sel | output | 16 | New stack selector |
| cs_attr | output | 8 | Code segment cached attributes |
| ss_attr | output | 8 | Stack segment cached attributes |
| seg_base | output | 64 | Segment base for both caches |
| seg_limit | output | 32 | Segment limit for both caches |
| ret_addr | output | 64 | Return address register value |
| saved_flags | output | 32 | Saved flags image |
| save_we | output | 1 | Saved flags image written this cycle |
| new_flags | output | 32 | New flags register |
| new_ip | output | 64 | New instruction pointer |

## Verification
The bench drives starts on consecutive cycles, so one request's result becomes visible in the same cycle that the next request is sampled. It also puts a fault request directly after a good load. This checks that the fault pulse and the hold of the state outputs do not disturb the load that came before, and that a long-mode load followed by a legacy load leaves the saved flags image unchanged. A behavioural model in the bench predicts every output each cycle. It and the design must agree on which of `done` and `fault` fires, and they must agree on the held values across the fault cycle.

// File: rtl/sce_pkg.sv
package sce_pkg;
  typedef struct packed {
    logic gran;
    logic present;
    logic non_sys;
    logic is_code;
    logic rw;
    logic accessed;
    logic long64;
    logic big;
  } seg_attr_t;

  localparam int FL_IF = 9;
  localparam int FL_RF = 16;
  localparam int FL_VM = 17;
endpackage

// File: rtl/sce_seg_gen.sv
module sce_seg_gen #(
  parameter int SEL_W = 16
) (
  input  logic [SEL_W-1:0]  base_sel,
  input  logic              long_mode,
  output logic [SEL_W-1:0]  cs_sel,
  output logic [SEL_W-1:0]  ss_sel,
  output sce_pkg::seg_attr_t cs_attr,
  output sce_pkg::seg_attr_t ss_attr
);
  localparam logic [SEL_W-1:0] RPL_CLR = ~(SEL_W'(3));
  localparam logic [SEL_W-1:0] SS_STEP = SEL_W'(8);

  always_comb begin
    cs_sel = base_sel & RPL_CLR;
    ss_sel = (base_sel + SS_STEP) & RPL_CLR;

    cs_attr          = '0;
    cs_attr.gran     = 1'b1;
    cs_attr.present  = 1'b1;
    cs_attr.non_sys  = 1'b1;
    cs_attr.is_code  = 1'b1;
    cs_attr.rw       = 1'b1;
    cs_attr.accessed = 1'b1;
    cs_attr.long64   = long_mode;
    cs_attr.big      = ~long_mode;

    ss_attr          = '0;
    ss_attr.gran     = 1'b1;
    ss_attr.present  = 1'b1;
    ss_attr.non_sys  = 1'b1;
    ss_attr.rw       = 1'b1;
    ss_attr.accessed = 1'b1;
    ss_attr.big      = 1'b1;
  end
endmodule

// File: rtl/sce_flag_gen.sv
module sce_flag_gen #(
  parameter int FLG_W = 32
) (
  input  logic [FLG_W-1:0] flags_in,
  input  logic [FLG_W-1:0] fmask,
  input  logic             long_mode,
  output logic [FLG_W-1:0] new_flags,
  output logic [FLG_W-1:0] saved_flags
);
  localparam logic [FLG_W-1:0] RF_BIT  = FLG_W'(1) << sce_pkg::FL_RF;
  localparam logic [FLG_W-1:0] LEG_CLR = (FLG_W'(1) << sce_pkg::FL_IF) |
                                         (FLG_W'(1) << sce_pkg::FL_VM) | RF_BIT;

  always_comb begin
    saved_flags = flags_in & ~RF_BIT;
    if (long_mode) new_flags = flags_in & ~(fmask | RF_BIT);
    else           new_flags = flags_in & ~LEG_CLR;
  end
endmodule

// File: rtl/sce_ip_gen.sv
module sce_ip_gen #(
  parameter int IP_W   = 64,
  parameter int ILEN_W = 4,
  parameter int LEG_W  = 32
) (
  input  logic [IP_W-1:0]   cur_ip,
  input  logic [ILEN_W-1:0] ilen,
  input  logic              long_mode,
  input  logic              cs64,
  input  logic [LEG_W-1:0]  leg_tgt,
  input  logic [IP_W-1:0]   tgt64,
  input  logic [IP_W-1:0]   tgt_compat,
  output logic [IP_W-1:0]   ret_addr,
  output logic [IP_W-1:0]   new_ip
);
  logic [IP_W-1:0] next_ip;

  always_comb begin
    next_ip = cur_ip + IP_W'(ilen);
    if (long_mode) begin
      ret_addr = next_ip;
      new_ip   = cs64 ? tgt64 : tgt_compat;
    end else begin
      ret_addr = IP_W'(next_ip[LEG_W-1:0]);
      new_ip   = IP_W'(leg_tgt);
    end
  end
endmodule

// File: rtl/syscall_entry_unit.sv
module syscall_entry_unit #(
  parameter int IP_W    = 64,
  parameter int ILEN_W  = 4,
  parameter int FLG_W   = 32,
  parameter int SEL_W   = 16,
  parameter int SEL_LSB = 32,
  parameter int LEG_W   = 32,
  parameter int LIM_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IP_W-1:0]   cur_ip,
  input  logic [ILEN_W-1:0] ilen,
  input  logic [FLG_W-1:0]  flags_in,
  input  logic              long_mode,
  input  logic              cs64,
  input  logic              sce_en,
  input  logic [IP_W-1:0]   sel_tgt,
  input  logic [IP_W-1:0]   tgt64,
  input  logic [IP_W-1:0]   tgt_compat,
  input  logic [FLG_W-1:0]  fmask,
  output logic              done,
  output logic              fault,
  output logic [15:0]       flt_code,
  output logic [SEL_W-1:0]  cs_sel,
  output logic [SEL_W-1:0]  ss_sel,
  output logic [7:0]        cs_attr,
  output logic [7:0]        ss_attr,
  output logic [IP_W-1:0]   seg_base,
  output logic [LIM_W-1:0]  seg_limit,
  output logic [IP_W-1:0]   ret_addr,
  output logic [FLG_W-1:0]  saved_flags,
  output logic              save_we,
  output logic [FLG_W-1:0]  new_flags,
  output logic [IP_W-1:0]   new_ip
);
  import sce_pkg::*;

  logic               go, bad;
  logic [SEL_W-1:0]   cs_c, ss_c;
  seg_attr_t          csa_c, ssa_c;
  logic [FLG_W-1:0]   nf_c, sf_c;
  logic [IP_W-1:0]    ra_c, ip_c;

  assign go  = start & sce_en;
  assign bad = start & ~sce_en;

  sce_seg_gen #(.SEL_W(SEL_W)) u_seg (
    .base_sel (sel_tgt[SEL_LSB +: SEL_W]),
    .long_mode(long_mode),
    .cs_sel   (cs_c),
    .ss_sel   (ss_c),
    .cs_attr  (csa_c),
    .ss_attr  (ssa_c)
  );

  sce_flag_gen #(.FLG_W(FLG_W)) u_flg (
    .flags_in   (flags_in),
    .fmask      (fmask),
    .long_mode  (long_mode),
    .new_flags  (nf_c),
    .saved_flags(sf_c)
  );

  sce_ip_gen #(.IP_W(IP_W), .ILEN_W(ILEN_W), .LEG_W(LEG_W)) u_ip (
    .cur_ip    (cur_ip),
    .ilen      (ilen),
    .long_mode (long_mode),
    .cs64      (cs64),
    .leg_tgt   (sel_tgt[LEG_W-1:0]),
    .tgt64     (tgt64),
    .tgt_compat(tgt_compat),
    .ret_addr  (ra_c),
    .new_ip    (ip_c)
  );

  assign flt_code = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      fault       <= 1'b0;
      save_we     <= 1'b0;
      cs_sel      <= '0;
      ss_sel      <= '0;
      cs_attr     <= '0;
      ss_attr     <= '0;
      seg_base    <= '0;
      seg_limit   <= '0;
      ret_addr    <= '0;
      saved_flags <= '0;
      new_flags   <= '0;
      new_ip      <= '0;
    end else begin
      done    <= go;
      fault   <= bad;
      save_we <= go & long_mode;
      if (go) begin
        cs_sel    <= cs_c;
        ss_sel    <= ss_c;
        cs_attr   <= csa_c;
        ss_attr   <= ssa_c;
        seg_base  <= '0;
        seg_limit <= '1;
        ret_addr  <= ra_c;
        new_flags <= nf_c;
        new_ip    <= ip_c;
        if (long_mode) saved_flags <= sf_c;
      end
    end
  end

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && fault)); // R3
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |-> $past(start)); // R3
  AST_FAULT_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($stable(new_ip) && $stable(cs_sel) && $stable(new_flags) && $stable(ret_addr))); // R2
  AST_SS_FOLLOWS_CS: assert property (@(posedge clk) disable iff (rst)
    done |-> (ss_sel == cs_sel + SEL_W'(8))); // R4
  AST_RF_CLEARED: assert property (@(posedge clk) disable iff (rst)
    done |-> !new_flags[FL_RF]); // R7
  AST_SAVE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    save_we |-> (done && cs_attr[1])); // R6
endmodule

// File: tb/syscall_entry_unit_bench.sv
`timescale 1ns/1ps
module syscall_entry_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [63:0] cur_ip = '0;
  logic [3:0]  ilen = '0;
  logic [31:0] flags_in = '0;
  logic long_mode = 1'b0, cs64 = 1'b0, sce_en = 1'b0;
  logic [63:0] sel_tgt = '0, tgt64 = '0, tgt_compat = '0;
  logic [31:0] fmask = '0;

  logic done, fault, save_we;
  logic [15:0] flt_code, cs_sel, ss_sel;
  logic [7:0]  cs_attr, ss_attr;
  logic [63:0] seg_base, ret_addr, new_ip;
  logic [31:0] seg_limit, saved_flags, new_flags;

  always #10 clk = ~clk;

  syscall_entry_unit u_syscall_entry_unit (
    .clk(clk), .rst(rst), .start(start), .cur_ip(cur_ip), .ilen(ilen),
    .flags_in(flags_in), .long_mode(long_mode), .cs64(cs64), .sce_en(sce_en),
    .sel_tgt(sel_tgt), .tgt64(tgt64), .tgt_compat(tgt_compat), .fmask(fmask),
    .done(done), .fault(fault), .flt_code(flt_code), .cs_sel(cs_sel),
    .ss_sel(ss_sel), .cs_attr(cs_attr), .ss_attr(ss_attr), .seg_base(seg_base),
    .seg_limit(seg_limit), .ret_addr(ret_addr), .saved_flags(saved_flags),
    .save_we(save_we), .new_flags(new_flags), .new_ip(new_ip)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // reference model state
  logic e_done, e_fault, e_we, e_long, e_rst;
  logic [15:0] e_cs, e_ss;
  logic [7:0]  e_csa, e_ssa;
  logic [63:0] e_base, e_ra, e_ip;
  logic [31:0] e_lim, e_sf, e_nf;
  logic [15:0] m_b;
  logic [63:0] m_nx;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    e_rst <= rst;
    if (rst) begin
      e_done <= 0; e_fault <= 0; e_we <= 0; e_long <= 0;
      e_cs <= 0; e_ss <= 0; e_csa <= 0; e_ssa <= 0; e_base <= 0; e_lim <= 0;
      e_ra <= 0; e_sf <= 0; e_nf <= 0; e_ip <= 0;
    end else begin
      e_done  <= start && sce_en;
      e_fault <= start && !sce_en;
      e_we    <= start && sce_en && long_mode;
      if (start && sce_en) begin
        m_b  = sel_tgt[47:32];
        m_nx = cur_ip + {60'd0, ilen};
        e_long <= long_mode;
        e_cs   <= m_b & 16'hFFFC;
        e_ss   <= (m_b + 16'd8) & 16'hFFFC;
        e_csa  <= long_mode ? 8'hFE : 8'hFD;
        e_ssa  <= 8'hED;
        e_base <= 64'd0;
        e_lim  <= 32'hFFFF_FFFF;
        if (long_mode) begin
          e_ra <= m_nx;
          e_sf <= flags_in & ~32'h0001_0000;
          e_nf <= flags_in & ~fmask & ~32'h0001_0000;
          e_ip <= cs64 ? tgt64 : tgt_compat;
        end else begin
          e_ra <= {32'd0, m_nx[31:0]};
          e_nf <= flags_in & ~32'h0003_0200;
          e_ip <= {32'd0, sel_tgt[31:0]};
        end
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      string rA, rB, rC, rD;
      rA = e_rst ? "R1" : "R3";
      rB = e_rst ? "R1" : "R2";
      rC = e_rst ? "R1" : (e_long ? "R6" : "R9");
      rD = e_rst ? "R1" : (e_long ? "R7" : "R10");
      chk(rA, "done", {63'd0, done}, {63'd0, e_done});
      chk(rB, "fault", {63'd0, fault}, {63'd0, e_fault});
      chk(rB, "flt_code", {48'd0, flt_code}, 64'd0);
      chk(e_rst ? "R1" : "R4", "cs_sel", {48'd0, cs_sel}, {48'd0, e_cs});
      chk(e_rst ? "R1" : "R4", "ss_sel", {48'd0, ss_sel}, {48'd0, e_ss});
      chk(e_rst ? "R1" : "R5", "cs_attr", {56'd0, cs_attr}, {56'd0, e_csa});
      chk(e_rst ? "R1" : "R5", "ss_attr", {56'd0, ss_attr}, {56'd0, e_ssa});
      chk(e_rst ? "R1" : "R5", "seg_base", seg_base, e_base);
      chk(e_rst ? "R1" : "R5", "seg_limit", {32'd0, seg_limit}, {32'd0, e_lim});
      chk(rC, "ret_addr", ret_addr, e_ra);
      chk(rC, "saved_flags", {32'd0, saved_flags}, {32'd0, e_sf});
      chk(rC, "save_we", {63'd0, save_we}, {63'd0, e_we});
      chk(rD, "new_flags", {32'd0, new_flags}, {32'd0, e_nf});
      chk(e_rst ? "R1" : (e_long ? "R8" : "R11"), "new_ip", new_ip, e_ip);
    end
  end

  task automatic req_call(input logic en, input logic lm, input logic c64,
                          input logic [63:0] ip, input logic [3:0] len,
                          input logic [31:0] fl, input logic [31:0] fm,
                          input logic [63:0] st);
    sce_en = en; long_mode = lm; cs64 = c64; cur_ip = ip; ilen = len;
    flags_in = fl; fmask = fm; sel_tgt = st;
    tgt64 = 64'hFFFF_8000_0010_0000; tgt_compat = 64'h0000_0000_C020_3000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R2: fault before any load, outputs stay zero
    req_call(1'b0, 1'b1, 1'b1, 64'h1000, 4'd2, 32'h0000_0202, 32'h0, 64'h0010_0000_0000);
    @(negedge clk);
    // R9 R10 R11: legacy, truncated return address, fmask ignored
    req_call(1'b1, 1'b0, 1'b0, 64'h1_2345_FFFE, 4'd3, 32'h0003_0202, 32'hFFFF_FFFF,
             64'h0023_0010_8000_1234);
    @(negedge clk);
    // R6 R7 R8: long mode, 64-bit caller, ip wraps
    req_call(1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 4'd2, 32'h0001_0246,
             32'h0004_7700, 64'h0000_001B_0000_0000);
    @(negedge clk);
    // R8: compatibility caller
    req_call(1'b1, 1'b1, 1'b0, 64'h0000_0000_0040_0100, 4'd2, 32'h0000_0a93,
             32'h0000_0200, 64'h0000_0033_0000_0000);
    // R2: fault right after a load holds the state
    req_call(1'b0, 1'b0, 1'b0, 64'h5555, 4'd2, 32'h0002_0000, 32'h0, 64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    // R4: selector base near top wraps the stack selector; R9 saved flags held
    req_call(1'b1, 1'b0, 1'b0, 64'h0000_0000_FFFF_FFFF, 4'd15, 32'hFFFF_FFFF, 32'h0,
             64'h0000_FFFE_0000_0010);
    // R3: back-to-back starts
    req_call(1'b1, 1'b1, 1'b1, 64'h7000, 4'd2, 32'h0003_0000, 32'h0001_0000,
             64'h0000_0008_0000_0000);
    req_call(1'b1, 1'b0, 1'b1, 64'h8000, 4'd1, 32'h0000_0200, 32'h0, 64'h0000_0003_0000_0042);
    req_call(1'b0, 1'b1, 1'b1, 64'h9000, 4'd2, 32'h0, 32'h0, 64'h0);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule